// File: doc/BRIEF.md
# SPI Master Serial Shift Engine

This block is the serial core of a synchronous serial port that works as bus master. When it is enabled and its transmit queue holds a word, it takes one word from the queue and shifts that frame out on MOSI, most significant bit first. At the same time it shifts a frame in from MISO. At the end of the frame it hands the received word to a receive queue. The serial clock comes from a divider in two stages: an even prescaler, then a rate divider that divides by (1 + rate). The serial bit rate is therefore the input clock divided by (prescale × (1 + rate)). Clock polarity and clock phase select any of the four SPI modes. The frame length can be 4 to 16 bits and is encoded as length minus one.

The frame settings (length, phase, polarity, loopback, prescale and rate) are captured when a frame starts. A loopback setting routes the block's own MOSI bit into its receive path, so that every frame sent returns as a received frame. The busy output stays high while a frame is being shifted or while the transmit queue is not empty. Firmware waits for busy to fall before it moves a chip select.

Top module: `spi_shift_master`

## Requirements
- R1: After reset, sclk equals cfg_cpol, mosi is 0, rx_push is 0, and busy and tx_pop both follow only the enable and tx_empty inputs.
- R2: The serial clock half-period is H = max(floor(cfg_prescale/2), 1) × (1 + cfg_rate) input cycles. The first edge of a frame comes H cycles after the cycle in which the frame is loaded.
- R3: While idle, sclk equals cfg_cpol. A frame of N bits toggles sclk exactly 2N times, starting from the polarity level that was captured when the frame started.
- R4: MOSI sends bits MSB first (bit N-1 of tx_data first). With phase 0, the first bit is on MOSI from the load cycle and each later bit changes on a trailing edge. With phase 1, MOSI is 0 until the first leading edge and each bit changes on a leading edge. MOSI is 0 while idle.
- R5: With phase 0, the receive bit is sampled on leading edges; with phase 1, on trailing edges. rx_push is a one-cycle pulse in the cycle after the final edge. rx_data holds the N received bits right-justified, first bit received in bit N-1, with zeros above.
- R6: The frame length is cfg_size_m1 + 1. Field values 0 to 2 give 4-bit frames.
- R7: With loopback set, the receive bit comes from the block's own MOSI and MISO is ignored. The returned word equals the sent word masked to N bits.
- R8: tx_pop is a one-cycle pulse in an idle cycle in which the block is enabled and tx_empty is low. tx_data is taken at that clock edge. Back-to-back frames are separated by exactly one idle cycle.
- R9: While cfg_enable is low, no word is taken from the queue. A frame already in flight still runs to completion.
- R10: busy is high exactly when a frame is in flight or tx_empty is low.
- R11: Configuration changes during a frame have no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_enable | input | 1 | Allows the block to start new frames |
| cfg_loopback | input | 1 | Routes MOSI into the receive path |
| cfg_cpol | input | 1 | Clock polarity (idle level of sclk) |
| cfg_cpha | input | 1 | Clock phase (0: sample on the leading edge) |
| cfg_size_m1 | input | 4 | Frame length minus one |
| cfg_prescale | input | 8 | Even prescale divisor, 2 to 254 |
| cfg_rate | input | 8 | Rate divider; divides by (1 + value) |
| tx_empty | input | 1 | Transmit queue is empty |
| tx_data | input | 16 | Head word of the transmit queue, right-justified |
| tx_pop | output | 1 | Takes the head word from the transmit queue |
| rx_push | output | 1 | Writes rx_data into the receive queue |
| rx_data | output | 16 | Received frame, right-justified |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| busy | output | 1 | Frame in flight or transmit queue not empty |

## Verification
The bench model counts the cycles since each load. At count c the number of edges done is floor(c/H), and that one number gives the expected sclk level and the MOSI bit index for each phase. tx_pop and busy are compared in the same cycle as the inputs that cause them. The model takes a frame on the clock edge that follows a cycle with tx_pop expected. sclk and mosi are compared in every cycle of the frame. rx_push and rx_data are expected exactly 2N·H cycles after the load edge. A behavioural slave in the bench drives MISO with the same phase rule, so sampling on the wrong edge shows up as wrong received data. All comparisons take place 1 ns after the falling clock edge, which keeps them clear of the rising edge where the design updates.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
  parameter int unsigned SPI_MAX_BITS = 16;
  localparam int unsigned SPI_LEN_W   = $clog2(SPI_MAX_BITS);
  localparam int unsigned SPI_MIN_LM1 = 3;

  typedef struct packed {
    logic [SPI_LEN_W-1:0] len_m1;
    logic                 cpha;
    logic                 loop;
  } spi_frame_cfg_t;
endpackage

// File: rtl/spi_bitclk_div.sv
module spi_bitclk_div #(
  parameter int unsigned PRE_W  = 8,
  parameter int unsigned RATE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [PRE_W-1:0]  prescale,
  input  logic [RATE_W-1:0] rate,
  output logic              half_tick
);
  localparam int unsigned HALF_W = PRE_W - 1;

  logic [HALF_W-1:0] half_lim;
  logic [HALF_W-1:0] pre_cnt_q, pre_cnt_d;
  logic [RATE_W-1:0] rate_cnt_q, rate_cnt_d;
  logic              pre_wrap;

  always_comb begin
    half_lim  = (prescale < PRE_W'(2)) ? HALF_W'(1) : prescale[PRE_W-1:1];
    pre_wrap  = (pre_cnt_q == half_lim - HALF_W'(1));
    half_tick = run && pre_wrap && (rate_cnt_q == rate);
    pre_cnt_d  = pre_cnt_q;
    rate_cnt_d = rate_cnt_q;
    if (!run) begin
      pre_cnt_d  = '0;
      rate_cnt_d = '0;
    end else if (pre_wrap) begin
      pre_cnt_d  = '0;
      rate_cnt_d = (rate_cnt_q == rate) ? '0 : rate_cnt_q + RATE_W'(1);
    end else begin
      pre_cnt_d = pre_cnt_q + HALF_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt_q  <= '0;
      rate_cnt_q <= '0;
    end else begin
      pre_cnt_q  <= pre_cnt_d;
      rate_cnt_q <= rate_cnt_d;
    end
  end

  AST_PRE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (pre_cnt_q < half_lim)) else $error("prescale counter out of range"); // R2
endmodule

// File: rtl/spi_frame_shifter.sv
module spi_frame_shifter
  import spi_eng_pkg::*;
#(
  parameter int unsigned W = SPI_MAX_BITS
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [W-1:0]   load_word,
  input  spi_frame_cfg_t load_cfg,
  input  logic           load_cpol,
  input  logic           half_tick,
  input  logic           miso,
  output logic           active,
  output logic           sclk_q,
  output logic           mosi,
  output logic           rx_push,
  output logic [W-1:0]   rx_word
);
  localparam int unsigned EDGE_W = SPI_LEN_W + 1;

  logic                active_q, active_d;
  logic [EDGE_W-1:0]   edge_q, edge_d;
  logic [W-1:0]        txsh_q, txsh_d;
  logic [W-1:0]        rxsh_q, rxsh_d;
  logic [W-1:0]        rxw_q, rxw_d;
  spi_frame_cfg_t      cfg_q, cfg_d;
  logic                sclk_d, mosi_q, mosi_d, push_q, push_d;
  logic                leading, sample_now, is_last, rx_bit;
  logic [EDGE_W-1:0]   last_edge;

  always_comb begin
    last_edge  = {cfg_q.len_m1, 1'b1};
    leading    = ~edge_q[0];
    sample_now = cfg_q.cpha ? ~leading : leading;
    is_last    = (edge_q == last_edge);
    rx_bit     = cfg_q.loop ? mosi_q : miso;

    active_d = active_q;
    edge_d   = edge_q;
    txsh_d   = txsh_q;
    rxsh_d   = rxsh_q;
    rxw_d    = rxw_q;
    cfg_d    = cfg_q;
    sclk_d   = sclk_q;
    mosi_d   = mosi_q;
    push_d   = 1'b0;

    if (load && !active_q) begin
      active_d = 1'b1;
      edge_d   = '0;
      txsh_d   = load_word;
      rxsh_d   = '0;
      cfg_d    = load_cfg;
      sclk_d   = load_cpol;
      mosi_d   = load_cfg.cpha ? 1'b0 : load_word[load_cfg.len_m1];
    end else if (active_q && half_tick) begin
      edge_d = edge_q + EDGE_W'(1);
      sclk_d = ~sclk_q;
      if (sample_now) rxsh_d = {rxsh_q[W-2:0], rx_bit};
      if (cfg_q.cpha && leading) begin
        mosi_d = txsh_q[cfg_q.len_m1];
        txsh_d = txsh_q << 1;
      end else if (!cfg_q.cpha && !leading && !is_last) begin
        txsh_d = txsh_q << 1;
        mosi_d = txsh_d[cfg_q.len_m1];
      end
      if (is_last) begin
        active_d = 1'b0;
        edge_d   = '0;
        mosi_d   = 1'b0;
        push_d   = 1'b1;
        rxw_d    = rxsh_d;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      edge_q   <= '0;
      txsh_q   <= '0;
      rxsh_q   <= '0;
      rxw_q    <= '0;
      cfg_q    <= '0;
      sclk_q   <= 1'b0;
      mosi_q   <= 1'b0;
      push_q   <= 1'b0;
    end else begin
      active_q <= active_d;
      edge_q   <= edge_d;
      txsh_q   <= txsh_d;
      rxsh_q   <= rxsh_d;
      rxw_q    <= rxw_d;
      cfg_q    <= cfg_d;
      sclk_q   <= sclk_d;
      mosi_q   <= mosi_d;
      push_q   <= push_d;
    end
  end

  assign active  = active_q;
  assign mosi    = mosi_q;
  assign rx_push = push_q;
  assign rx_word = rxw_q;

  AST_EDGE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (edge_q <= last_edge)) else $error("edge count past frame end"); // R3
  AST_SCLK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !half_tick && !load) |=> $stable(sclk_q)) else $error("sclk moved without tick"); // R2
  AST_PUSH_ENDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    push_q |-> (!active_q && $past(active_q))) else $error("push without frame end"); // R5
endmodule

// File: rtl/spi_shift_master.sv
module spi_shift_master
  import spi_eng_pkg::*;
#(
  parameter int unsigned DATA_W = SPI_MAX_BITS,
  parameter int unsigned PRE_W  = 8,
  parameter int unsigned RATE_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_enable,
  input  logic                 cfg_loopback,
  input  logic                 cfg_cpol,
  input  logic                 cfg_cpha,
  input  logic [SPI_LEN_W-1:0] cfg_size_m1,
  input  logic [PRE_W-1:0]     cfg_prescale,
  input  logic [RATE_W-1:0]    cfg_rate,
  input  logic                 tx_empty,
  input  logic [DATA_W-1:0]    tx_data,
  output logic                 tx_pop,
  output logic                 rx_push,
  output logic [DATA_W-1:0]    rx_data,
  output logic                 sclk,
  output logic                 mosi,
  input  logic                 miso,
  output logic                 busy
);
  logic              active, sclk_q, half_tick;
  logic [PRE_W-1:0]  pre_q, pre_d;
  logic [RATE_W-1:0] rate_q, rate_d;
  spi_frame_cfg_t    new_cfg;

  always_comb begin
    tx_pop         = !active && cfg_enable && !tx_empty;
    new_cfg.len_m1 = (cfg_size_m1 < SPI_LEN_W'(SPI_MIN_LM1)) ? SPI_LEN_W'(SPI_MIN_LM1)
                                                              : cfg_size_m1;
    new_cfg.cpha   = cfg_cpha;
    new_cfg.loop   = cfg_loopback;
    pre_d          = tx_pop ? cfg_prescale : pre_q;
    rate_d         = tx_pop ? cfg_rate     : rate_q;
    sclk           = active ? sclk_q : cfg_cpol;
    busy           = active || !tx_empty;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      rate_q <= '0;
    end else begin
      pre_q  <= pre_d;
      rate_q <= rate_d;
    end
  end

  spi_bitclk_div #(.PRE_W(PRE_W), .RATE_W(RATE_W)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (active),
    .prescale  (pre_q),
    .rate      (rate_q),
    .half_tick (half_tick)
  );

  spi_frame_shifter #(.W(DATA_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (tx_pop),
    .load_word (tx_data),
    .load_cfg  (new_cfg),
    .load_cpol (cfg_cpol),
    .half_tick (half_tick),
    .miso      (miso),
    .active    (active),
    .sclk_q    (sclk_q),
    .mosi      (mosi),
    .rx_push   (rx_push),
    .rx_word   (rx_data)
  );

  AST_POP_STARTS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |=> active) else $error("pop did not start a frame"); // R8
  AST_MOSI_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !mosi) else $error("mosi high while idle"); // R4
endmodule

// File: tb/tb_spi_shift_master.sv
`timescale 1ns/1ps
module tb_spi_shift_master;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_enable, cfg_loopback, cfg_cpol, cfg_cpha;
  logic [3:0]  cfg_size_m1;
  logic [7:0]  cfg_prescale, cfg_rate;
  logic        tx_empty;
  logic [15:0] tx_data;
  logic        tx_pop, rx_push, sclk, mosi, miso, busy;
  logic [15:0] rx_data;

  always #10 clk = ~clk;

  spi_shift_master dut (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_loopback(cfg_loopback),
    .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_size_m1(cfg_size_m1),
    .cfg_prescale(cfg_prescale), .cfg_rate(cfg_rate), .tx_empty(tx_empty),
    .tx_data(tx_data), .tx_pop(tx_pop), .rx_push(rx_push), .rx_data(rx_data),
    .sclk(sclk), .mosi(mosi), .miso(miso), .busy(busy)
  );

  int errs = 0, checks = 0;
  bit finished = 0;
  int txq[$];
  int slq[$];
  bit m_active = 0, m_cpol, m_cpha, m_lb, exp_push = 0, exp_pop;
  int m_c, m_n, m_h, m_word, m_slv, exp_rx;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int line_bit(int word, int n, bit cpha, int c, int h);
    int ed = c / h;
    int i;
    if (cpha) begin
      if (ed == 0) return 0;
      i = (ed - 1) / 2;
    end else i = ed / 2;
    return (word >> (n - 1 - i)) & 1;
  endfunction

  task automatic step();
    bit sb;
    tx_empty = (txq.size() == 0);
    tx_data  = tx_empty ? 16'h0 : 16'(txq[0]);
    sb = m_active ? line_bit(m_slv, m_n, m_cpha, m_c, m_h) != 0 : 1'b0;
    miso = (m_active && m_lb) ? ~sb : sb;
    #1;
    exp_pop = !m_active && cfg_enable && (txq.size() > 0);
    chk("R8 R9 tx_pop", int'(tx_pop), int'(exp_pop));
    chk("R10 busy", int'(busy), int'(m_active || txq.size() > 0));
    chk("R2 R3 R11 sclk", int'(sclk),
        m_active ? int'(m_cpol) ^ ((m_c / m_h) & 1) : int'(cfg_cpol));
    chk("R4 R6 mosi", int'(mosi),
        m_active ? line_bit(m_word, m_n, m_cpha, m_c, m_h) : 0);
    chk("R5 rx_push", int'(rx_push), int'(exp_push));
    if (exp_push) chk("R5 R7 rx_data", int'(rx_data), exp_rx);
    @(posedge clk);
    exp_push = 0;
    if (m_active) begin
      m_c++;
      if (m_c == 2 * m_n * m_h) begin
        m_active = 0;
        exp_push = 1;
        exp_rx = (m_lb ? m_word : m_slv) & ((1 << m_n) - 1);
      end
    end else if (exp_pop) begin
      int half;
      m_n = ((cfg_size_m1 < 3) ? 3 : int'(cfg_size_m1)) + 1;
      half = int'(cfg_prescale) / 2;
      if (half == 0) half = 1;
      m_h = half * (int'(cfg_rate) + 1);
      m_cpol = cfg_cpol; m_cpha = cfg_cpha; m_lb = cfg_loopback;
      m_word = txq.pop_front();
      m_slv  = slq.pop_front();
      m_c = 0;
      m_active = 1;
    end
    @(negedge clk);
  endtask

  task automatic steps(int k);
    for (int i = 0; i < k; i++) step();
  endtask

  task automatic drain();
    while (txq.size() > 0 || m_active || exp_push) step();
    steps(2);
  endtask

  task automatic setcfg(bit pol, bit pha, int sz, int cps, int scr, bit lb);
    cfg_cpol = pol; cfg_cpha = pha; cfg_size_m1 = 4'(sz);
    cfg_prescale = 8'(cps); cfg_rate = 8'(scr); cfg_loopback = lb;
  endtask

  task automatic send(int w, int s);
    txq.push_back(w); slq.push_back(s);
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_enable = 1'b1; miso = 1'b0; tx_empty = 1'b1; tx_data = '0;
    setcfg(0, 0, 7, 2, 0, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    chk("R1 sclk", int'(sclk), 0);
    chk("R1 mosi", int'(mosi), 0);
    chk("R1 rx_push", int'(rx_push), 0);
    chk("R1 busy", int'(busy), 0);
    steps(3);

    // R7: loopback, mode 0, 8-bit, fastest clock, back-to-back frames (R8)
    setcfg(0, 0, 7, 2, 0, 1);
    send(16'h00A5, 16'h0000); send(16'h013C, 16'hFFFF);
    drain();

    // four modes, 16-bit, slave on MISO (R4 R5)
    for (int m = 0; m < 4; m++) begin
      setcfg(m[1], m[0], 15, 4, 2, 0);
      send(16'hC3A1 ^ m, 16'h5E27 + m);
      send(16'h8001, 16'h7FFE);
      drain();
    end

    // R6: short frames and clamp, odd and zero prescale (R2)
    setcfg(1, 0, 3, 3, 1, 0);
    send(16'h000B, 16'h0006); drain();
    setcfg(0, 1, 0, 0, 1, 0);
    send(16'hFFF9, 16'h0005); drain();
    setcfg(0, 0, 4, 254, 0, 0);
    send(16'h0015, 16'h000A); drain();

    // R9: disabled with queued data, then disable mid-frame
    cfg_enable = 1'b0;
    setcfg(0, 1, 7, 2, 1, 0);
    send(16'h0066, 16'h0099); send(16'h0017, 16'h00E8);
    steps(12);
    chk("R9 no pop while disabled", int'(m_active), 0);
    cfg_enable = 1'b1;
    steps(4);
    cfg_enable = 1'b0;
    while (m_active || exp_push) step();
    steps(20);
    chk("R9 second frame held", txq.size(), 1);
    cfg_enable = 1'b1;
    drain();

    // R11: config flips mid-frame
    setcfg(1, 1, 11, 6, 0, 0);
    send(16'h0ABC, 16'h0123);
    steps(8);
    setcfg(0, 0, 3, 2, 3, 1);
    drain();

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule